// File: doc/BRIEF.md
# Streaming Bit-Matrix Transposer

The block takes a square tile of N words, each N bits wide, as a stream of words and emits the bit-transposed tile as a second stream of words. Bit i of output word j equals bit j of input word i. It is meant for a copy path next to memory. Records that each carry one flag bit become, after a pass, a single word holding that flag for N records. Word-wide logic can then filter all N records at once. A second pass through the block scatters the filtered bits back to their records.

Both streams use valid/ready handshakes. A word moves on a clock edge where valid and ready are both high. The producer may drop `in_valid` between words. The consumer may hold `out_ready` low for any number of cycles. While it does, `out_valid`, `out_data` and `out_last` stay fixed. Two tile buffers alternate, so one tile can load while the previous one drains. This sustains one word per cycle in both directions. `in_ready` falls only when both buffers hold tiles.

Top module: `bitmat_transposer`

## Requirements
- R1: For a tile size N of 32 or 64 (default 32), output word j of a tile has bit i equal to bit j of input word i of the same tile, for every i and j in 0..N-1.
- R2: Input words are taken as word 0 first and output words leave as word 0 first. No output word of a tile is offered before all N of its input words have been accepted.
- R3: With `in_valid` and `out_ready` held high and T tiles offered, `in_ready` never falls. The span from the first input transfer to the last output transfer is exactly (T+1)*N cycles.
- R4: `in_ready` is low only while both buffers hold tiles. With `out_ready` held low from empty, exactly 2N words are accepted, then `in_ready` falls while `out_valid` is high.
- R5: Once `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high with `out_data` and `out_last` unchanged.
- R6: `out_last` is high exactly on output word N-1 of every tile and low on every other offered word.
- R7: While synchronous `rst` is high, both buffers are emptied and any partly loaded tile is discarded. One cycle after a reset edge, `out_valid` is 0 and `in_ready` is 1. The next tile after reset is emitted correctly.
- R8: Passing a tile's output back in as a new tile returns the original tile word for word.
- R9: The first word of a tile loaded into an idle block is offered in the cycle right after its last input word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | N | Input word, row of the tile |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | N | Output word, column of the input tile |
| out_last | output | 1 | Marks the final word of a tile |

## Verification
The assertions assume only that `rst` is high at the first clock edge and that N is at least 2. They make no assumption about `in_valid` staying high or `in_data` staying fixed, because the block never requires either. The stimulus leaves the valid and ready lines free to toggle in several gap patterns. Its expected values rest on the assumption that every run starts on a tile boundary. To keep to that, partly loaded tiles only ever appear right before a reset, and every other sequence offers whole tiles.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // Which of the two tile buffers a pointer selects.
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bt_bank_e;

  function automatic bt_bank_e bt_flip(input bt_bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/bt_tile_buf.sv
module bt_tile_buf #(
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [N-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [N-1:0]  rcol
);
  // One row per input word; a read gathers one bit column.
  logic [N-1:0] rows [N];

  always_ff @(posedge clk) begin
    if (we) rows[waddr] <= wdata;
  end

  always_comb begin
    for (int r = 0; r < N; r++) rcol[r] = rows[r][raddr];
  end
endmodule

// File: rtl/bt_wr_ctrl.sv
module bt_wr_ctrl #(
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  output bt_pkg::bt_bank_e wbank,
  output logic [AW-1:0]    wptr,
  output logic             tile_done
);
  import bt_pkg::*;
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  assign tile_done = accept && (wptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      wbank <= BANK_A;
    end else if (accept) begin
      if (wptr == LAST) begin
        wptr  <= '0;
        wbank <= bt_flip(wbank);
      end else begin
        wptr <= wptr + 1'b1;
      end
    end
  end

  AST_WBANK_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (wbank != $past(wbank)) |-> (wptr == '0)) else $error("bank switch off boundary"); // R2
endmodule

// File: rtl/bt_rd_ctrl.sv
module bt_rd_ctrl #(
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  output bt_pkg::bt_bank_e rbank,
  output logic [AW-1:0]    rptr,
  output logic             tile_end
);
  import bt_pkg::*;
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  assign tile_end = (rptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr  <= '0;
      rbank <= BANK_A;
    end else if (take) begin
      if (tile_end) begin
        rptr  <= '0;
        rbank <= bt_flip(rbank);
      end else begin
        rptr <= rptr + 1'b1;
      end
    end
  end

  AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(rptr) && $stable(rbank)) else $error("read pointer moved without transfer"); // R5
endmodule

// File: rtl/bt_occupancy.sv
module bt_occupancy (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_set,
  input  bt_pkg::bt_bank_e fill_bank,
  input  logic             drain_clr,
  input  bt_pkg::bt_bank_e drain_bank,
  output logic [1:0]       full
);
  import bt_pkg::*;
  logic fb, db;
  assign fb = (fill_bank == BANK_B);
  assign db = (drain_bank == BANK_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 2'b00;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (fill_set && (fb == b[0]))       full[b] <= 1'b1;
        else if (drain_clr && (db == b[0])) full[b] <= 1'b0;
      end
    end
  end

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
    fill_set |-> !full[fb]) else $error("tile written into a full buffer"); // R4
  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    drain_clr |-> full[db]) else $error("drained an empty buffer"); // R2
endmodule

// File: rtl/bitmat_transposer.sv
module bitmat_transposer #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_data,
  output logic         out_last
);
  import bt_pkg::*;
  localparam int AW = $clog2(N);

  bt_bank_e      wbank, rbank;
  logic [AW-1:0] wptr, rptr;
  logic          accept, take, tile_done, tile_end;
  logic [1:0]    full;
  logic [N-1:0]  col [2];

  assign in_ready  = !full[wbank == BANK_B];
  assign out_valid = full[rbank == BANK_B];
  assign accept    = in_valid && in_ready;
  assign take      = out_valid && out_ready;
  assign out_data  = col[rbank == BANK_B];
  assign out_last  = out_valid && tile_end;

  bt_wr_ctrl #(.N(N)) u_wr (
    .clk(clk), .rst(rst), .accept(accept),
    .wbank(wbank), .wptr(wptr), .tile_done(tile_done)
  );

  bt_rd_ctrl #(.N(N)) u_rd (
    .clk(clk), .rst(rst), .take(take),
    .rbank(rbank), .rptr(rptr), .tile_end(tile_end)
  );

  bt_occupancy u_occ (
    .clk(clk), .rst(rst),
    .fill_set(tile_done), .fill_bank(wbank),
    .drain_clr(take && tile_end), .drain_bank(rbank),
    .full(full)
  );

  for (genvar g = 0; g < 2; g++) begin : g_buf
    bt_tile_buf #(.N(N)) u_buf (
      .clk(clk),
      .we(accept && ((wbank == BANK_B) == g[0])),
      .waddr(wptr), .wdata(in_data),
      .raddr(rptr), .rcol(col[g])
    );
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last))
    else $error("output changed while stalled"); // R5
  AST_BLOCK_NEEDS_TILE: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid) else $error("input blocked with nothing to drain"); // R4
  AST_LAST_SPACING: assert property (@(posedge clk) disable iff (rst)
    (take && out_last) |=> !out_last) else $error("tile marker on consecutive words"); // R6
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready) else $error("reset left data behind"); // R7
endmodule

// File: tb/sim_bitmat_transposer.sv
module sim_bitmat_transposer;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [N-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [N-1:0] out_data;

  always #4 clk = ~clk; // 125 MHz

  bitmat_transposer #(.N(N)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int nchk = 0, nfail = 0, wd = 0;
  logic [N-1:0] src_q[$], exp_q[$], got_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  function automatic logic [N-1:0] word_gen(input int t, input int w);
    logic [63:0] x;
    if (t < N * N) return (w == t / N) ? (N'(1) << (t % N)) : '0;
    x = (64'(t) * 64'h9E3779B97F4A7C15) ^ (64'(w + 1) * 64'hC2B2AE3D27D4EB4F);
    x = x ^ (x >> 29);
    return x[N-1:0];
  endfunction

  // Queue a tile and its bit-transposed expectation (R1 mapping).
  task automatic add_tile(input logic [N-1:0] w [N]);
    logic [N-1:0] e;
    for (int r = 0; r < N; r++) src_q.push_back(w[r]);
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) e[i] = w[i][j];
      exp_q.push_back(e);
    end
  endtask

  task automatic add_gen(input int t);
    logic [N-1:0] w [N];
    for (int r = 0; r < N; r++) w[r] = word_gen(t, r);
    add_tile(w);
  endtask

  function automatic bit mode_on(input int m, input int c);
    if (m == 0) return 1'b1;
    if (m == 1) return ((c * 7 + 3) % 5 != 0) && (c % 11 != 4);
    return (c % 3) == 0;
  endfunction

  // Streams all queued words and checks every offered output word.
  task automatic run(input int imode, input int omode, output int span, output bit blocked);
    bit in_fire = 0, out_fire = 0, stall = 0;
    logic [N-1:0] fire_data = '0, prev = '0;
    int cyc = 0, out_cnt = 0, first_in = -1, last_out = -1;
    blocked = 0;
    while (1) begin
      @(negedge clk);
      if (in_fire) void'(src_q.pop_front());
      if (out_fire) begin
        got_q.push_back(fire_data);
        void'(exp_q.pop_front());
        out_cnt++;
      end
      if (src_q.size() == 0 && exp_q.size() == 0) break;
      cyc++;
      in_valid  = (src_q.size() > 0) && mode_on(imode, cyc);
      in_data   = in_valid ? src_q[0] : '0;
      out_ready = mode_on(omode, cyc + 1);
      #1;
      if (stall) chk(out_valid && out_data == prev, "R5 held word", {out_valid, out_data}, {1'b1, prev});
      if (out_valid) begin
        if (exp_q.size() == 0) chk(0, "R2 spurious word", out_data, '0);
        else begin
          chk(out_data == exp_q[0], "R1 transpose", out_data, exp_q[0]);
          chk(out_last == (out_cnt % N == N - 1), "R6 last marker", out_last, out_cnt % N == N - 1);
        end
      end
      if (in_valid && !in_ready) blocked = 1;
      in_fire  = in_valid && in_ready;
      out_fire = out_valid && out_ready;
      if (in_fire && first_in < 0) first_in = cyc;
      if (out_fire) last_out = cyc;
      fire_data = out_data;
      stall = out_valid && !out_ready;
      prev = out_data;
    end
    in_valid = 0;
    out_ready = 0;
    span = last_out - first_in + 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    src_q.delete(); exp_q.delete(); got_q.delete();
  endtask

  initial begin
    int span, acc;
    bit blk;
    logic [N-1:0] orig [N];
    logic [N-1:0] back [N];

    // R7 reset state
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(!out_valid && in_ready, "R7 reset state", {out_valid, in_ready}, 2'b01);

    // R2 / R9: no offer before the last word, first word right after it
    out_ready = 0;
    for (int w = 0; w < N; w++) begin
      @(negedge clk);
      in_valid = 1; in_data = word_gen(N * N + 5, w);
      #1;
      chk(!out_valid, "R2 early output", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 0;
    #1;
    add_gen(N * N + 5);
    src_q.delete();
    chk(out_valid && !out_last, "R9 first word offered", {out_valid, out_last}, 2'b10);
    chk(out_data == exp_q[0], "R9 first word value", out_data, exp_q[0]);
    run(0, 1, span, blk);

    // R3: exhaustive single-bit tiles at full rate
    for (int t = 0; t < N * N; t++) add_gen(t);
    run(0, 0, span, blk);
    chk(!blk, "R3 ready stayed high", blk, 0);
    chk(span == (N * N + 1) * N, "R3 sustained span", span, (N * N + 1) * N);

    // Varied gap patterns on dense tiles
    for (int t = 0; t < 12; t++) add_gen(N * N + 100 + t);
    run(1, 1, span, blk);
    for (int t = 0; t < 12; t++) add_gen(N * N + 200 + t);
    run(0, 2, span, blk);
    for (int t = 0; t < 12; t++) add_gen(N * N + 300 + t);
    run(2, 0, span, blk);

    // R4: consumer stalled from empty
    do_reset();
    add_gen(N * N + 400); add_gen(N * N + 401);
    acc = 0;
    for (int c = 0; c < 3 * N; c++) begin
      @(negedge clk);
      in_valid = 1; in_data = (acc < 2 * N) ? src_q[acc] : '1;
      out_ready = 0;
      #1;
      if (in_ready) acc++;
    end
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(acc == 2 * N, "R4 accepted words", acc, 2 * N);
    chk(!in_ready && out_valid, "R4 blocked state", {in_ready, out_valid}, 2'b01);
    src_q.delete();
    run(0, 1, span, blk);

    // R7: partial tile discarded by reset
    do_reset();
    for (int w = 0; w < N / 2; w++) begin
      @(negedge clk);
      in_valid = 1; in_data = '1;
    end
    @(negedge clk);
    in_valid = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    #1;
    chk(!out_valid && in_ready, "R7 after mid-load reset", {out_valid, in_ready}, 2'b01);
    add_gen(N * N + 500);
    run(0, 0, span, blk);

    // R8: second pass restores the tile
    do_reset();
    for (int r = 0; r < N; r++) orig[r] = word_gen(N * N + 600, r);
    add_tile(orig);
    run(0, 0, span, blk);
    for (int r = 0; r < N; r++) back[r] = got_q[r];
    got_q.delete();
    add_tile(back);
    run(1, 1, span, blk);
    for (int r = 0; r < N; r++)
      chk(got_q[r] == orig[r], "R8 round trip", got_q[r], orig[r]);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule